// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

This block moves 8-bit time slots between eight serial input streams and eight serial output streams. Every clock cycle carries one bit on each stream. During a frame, the bytes that arrive on the inputs are collected into a data memory. Each output channel is built from its own connection-memory entry. The entry names a source stream and channel, and it carries two control bits: one that enables the channel and one that replaces switched data with a fixed message byte supplied by software.

A frame pulse marks the first bit of a frame and realigns the bit and channel counters. Between pulses the frames follow one another at a fixed length. A two-bit rate field sets the number of channels per stream, and with it how a source address splits into a stream part and a channel part. Software loads entries through a single-cycle write port. The entries are staged, so a change reaches the outputs only at the next frame start. The data memory holds two banks, so every output byte comes from the previous complete frame.

Top module: `tdm_tsi`

## Requirements
- R1: `rate_sel` sets the channels per stream: 00 gives 32, 01 gives 64, 10 gives 128, and the unused code 11 behaves like 00. A frame lasts 8 times the channel count in cycles.
- R2: A cycle with `frame_i` high is bit 7 of channel 0, whatever the counters held before. Without a pulse, the frame wraps to channel 0 bit 7 right after the last bit of the last channel.
- R3: Within a channel, bits leave most significant first: the cycle at offset k in the channel carries bit 7-k of the byte. Inputs are collected in the same order.
- R4: An enabled, non-message output channel carries the byte that arrived in the previous frame at the source address held in its entry. The channel part of the address is its low 5, 6 or 7 bits for 32, 64 or 128 channels. The stream part is the next 3 bits above it, and any bits above those are ignored.
- R5: When an entry's enable bit is 0, `ser_oe` for that stream is low for the whole channel and `ser_o` is 0. When the bit is 1, `ser_oe` is high for the whole channel.
- R6: When an entry's message bit is 1 and its enable bit is 1, the channel carries the entry's message byte instead of switched data.
- R7: A connection-memory write issued at any time in a frame takes effect from the next frame start. Until then, every channel of the current frame uses the entry that was in force when the frame started.
- R8: After reset every entry is cleared, so all outputs are disabled and `ser_o` and `ser_oe` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock: one bit per stream per cycle |
| rst | input | 1 | Synchronous reset, active high |
| frame_i | input | 1 | High in the first bit cycle of a frame |
| rate_sel | input | 2 | Channel count per stream (see R1) |
| ser_i | input | 8 | One input bit per serial stream |
| ser_o | output | 8 | One output bit per serial stream |
| ser_oe | output | 8 | Per-stream drive enable for the current channel |
| cfg_we | input | 1 | Connection-memory write strobe |
| cfg_stream | input | 3 | Output stream of the entry being written |
| cfg_chan | input | 7 | Output channel of the entry being written |
| cfg_oe | input | 1 | Enable bit of the new entry |
| cfg_msg | input | 1 | Message bit of the new entry |
| cfg_src | input | 10 | Source address of the new entry (split per R4) |
| cfg_byte | input | 8 | Message byte of the new entry |

## Verification
The assertions assume that `rate_sel` changes only while the counters are being realigned. They also assume that any `frame_i` pulse which should define the frame length arrives at a channel boundary. The stimulus changes the rate only in idle cycles before a test and then starts that test with a pulse. Any frame that follows a rate change or an idle stretch is used only to fill the previous-frame bank and is never checked. Software writes happen either between tests or at a fixed point inside a frame, far from the frame edges.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
    localparam int STREAMS = 8;
    localparam int STR_W   = $clog2(STREAMS);
    localparam int MAX_CH  = 128;
    localparam int CH_W    = $clog2(MAX_CH);
    localparam int SRC_W   = STR_W + CH_W;
    localparam int POS_W   = CH_W + 3;

    typedef enum logic [1:0] {
        RATE_LOW  = 2'b00,
        RATE_MID  = 2'b01,
        RATE_HIGH = 2'b10,
        RATE_RSV  = 2'b11
    } rate_e;

    typedef struct packed {
        logic             oe;
        logic             msg;
        logic [SRC_W-1:0] src;
        logic [7:0]       mbyte;
    } cm_entry_t;

    // channel-address width for a rate code; the lowest rate has a quarter of MAX_CH
    function automatic int unsigned chan_bits(input logic [1:0] r);
        case (rate_e'(r))
            RATE_MID:  return CH_W - 1;
            RATE_HIGH: return CH_W;
            default:   return CH_W - 2;
        endcase
    endfunction
endpackage

// File: rtl/tsi_timing.sv
module tsi_timing
    import tsi_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_i,
    input  logic [1:0]       rate_sel,
    output logic [POS_W-1:0] pos,
    output logic             frame_start,
    output logic             byte_end,
    output logic [CH_W-1:0]  chan,
    output logic [2:0]       bit_sel
);
    typedef struct packed {
        logic [POS_W-1:0] cnt;
    } tim_t;

    tim_t             s_q, s_d;
    logic [POS_W-1:0] last;

    always_comb begin
        last        = POS_W'((1 << (chan_bits(rate_sel) + 3)) - 1);
        pos         = frame_i ? '0 : (s_q.cnt & last);
        s_d         = s_q;
        s_d.cnt     = (pos == last) ? '0 : pos + 1'b1;
        frame_start = (pos == '0);
        byte_end    = (pos[2:0] == 3'd7);
        chan        = pos[POS_W-1:3];
        bit_sel     = ~pos[2:0];
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end
endmodule

// File: rtl/tsi_rx_store.sv
module tsi_rx_store
    import tsi_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [STREAMS-1:0] ser_i,
    input  logic               frame_start,
    input  logic               byte_end,
    input  logic [CH_W-1:0]    chan,
    input  logic [STR_W-1:0]   rd_str  [STREAMS],
    input  logic [CH_W-1:0]    rd_ch   [STREAMS],
    output logic [7:0]         rd_byte [STREAMS]
);
    typedef struct packed {
        logic                    bank;
        logic [STREAMS-1:0][6:0] sh;
    } rx_t;

    rx_t  s_q, s_d;
    logic cur_bank;
    logic [7:0] dmem_q [2][STREAMS][MAX_CH];

    always_comb begin
        s_d      = s_q;
        cur_bank = s_q.bank ^ frame_start;
        s_d.bank = cur_bank;
        for (int s = 0; s < STREAMS; s++) begin
            s_d.sh[s] = {s_q.sh[s][5:0], ser_i[s]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    // completed bytes land in the bank being filled this frame
    always_ff @(posedge clk) begin
        if (byte_end) begin
            for (int s = 0; s < STREAMS; s++) begin
                dmem_q[cur_bank][s][chan] <= {s_q.sh[s], ser_i[s]};
            end
        end
    end

    for (genvar g = 0; g < STREAMS; g++) begin : g_rd
        assign rd_byte[g] = dmem_q[~cur_bank][rd_str[g]][rd_ch[g]];
    end
endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem
    import tsi_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [STR_W-1:0] cfg_stream,
    input  logic [CH_W-1:0]  cfg_chan,
    input  cm_entry_t        cfg_entry,
    input  logic             frame_start,
    input  logic [CH_W-1:0]  chan,
    output cm_entry_t        cur [STREAMS]
);
    cm_entry_t shd_q [STREAMS][MAX_CH];
    cm_entry_t act_q [STREAMS][MAX_CH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STREAMS; s++) begin
                for (int c = 0; c < MAX_CH; c++) begin
                    shd_q[s][c] <= '0;
                    act_q[s][c] <= '0;
                end
            end
        end else begin
            if (cfg_we) shd_q[cfg_stream][cfg_chan] <= cfg_entry;
            if (frame_start) act_q <= shd_q;
        end
    end

    // the staged copy is taken at the end of the first bit cycle, so channel 0 reads it directly then
    for (genvar g = 0; g < STREAMS; g++) begin : g_sel
        assign cur[g] = frame_start ? shd_q[g][0] : act_q[g][chan];
    end
endmodule

// File: rtl/tdm_tsi.sv
module tdm_tsi
    import tsi_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_i,
    input  logic [1:0]         rate_sel,
    input  logic [STREAMS-1:0] ser_i,
    output logic [STREAMS-1:0] ser_o,
    output logic [STREAMS-1:0] ser_oe,
    input  logic               cfg_we,
    input  logic [STR_W-1:0]   cfg_stream,
    input  logic [CH_W-1:0]    cfg_chan,
    input  logic               cfg_oe,
    input  logic               cfg_msg,
    input  logic [SRC_W-1:0]   cfg_src,
    input  logic [7:0]         cfg_byte
);
    logic [POS_W-1:0] pos;
    logic             frame_start, byte_end;
    logic [CH_W-1:0]  chan;
    logic [2:0]       bit_sel;
    cm_entry_t        cfg_entry;
    cm_entry_t        cur     [STREAMS];
    logic [STR_W-1:0] src_str [STREAMS];
    logic [CH_W-1:0]  src_ch  [STREAMS];
    logic [7:0]       rd_byte [STREAMS];
    int unsigned      cb;
    logic [SRC_W-1:0] ch_mask;

    assign cfg_entry = '{oe: cfg_oe, msg: cfg_msg, src: cfg_src, mbyte: cfg_byte};

    always_comb begin
        cb      = chan_bits(rate_sel);
        ch_mask = (SRC_W'(1) << cb) - 1'b1;
    end

    tsi_timing u_timing (
        .clk(clk), .rst(rst), .frame_i(frame_i), .rate_sel(rate_sel),
        .pos(pos), .frame_start(frame_start), .byte_end(byte_end),
        .chan(chan), .bit_sel(bit_sel)
    );

    tsi_rx_store u_rx (
        .clk(clk), .rst(rst), .ser_i(ser_i), .frame_start(frame_start),
        .byte_end(byte_end), .chan(chan), .rd_str(src_str), .rd_ch(src_ch),
        .rd_byte(rd_byte)
    );

    tsi_conn_mem u_cm (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_stream(cfg_stream),
        .cfg_chan(cfg_chan), .cfg_entry(cfg_entry), .frame_start(frame_start),
        .chan(chan), .cur(cur)
    );

    for (genvar g = 0; g < STREAMS; g++) begin : g_tx
        logic [7:0] sel_byte;
        always_comb begin
            src_str[g] = STR_W'(cur[g].src >> cb);
            src_ch[g]  = CH_W'(cur[g].src & ch_mask);
            sel_byte   = cur[g].msg ? cur[g].mbyte : rd_byte[g];
            ser_o[g]   = cur[g].oe & sel_byte[bit_sel];
            ser_oe[g]  = cur[g].oe;
        end
    end
endmodule

// File: rtl/tdm_tsi_chk.sv
module tdm_tsi_chk
    import tsi_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               frame_i,
    input logic [1:0]         rate_sel,
    input logic [STREAMS-1:0] ser_oe,
    input logic [POS_W-1:0]   pos
);
    logic             ok_q;
    logic [1:0]       sync_rate_q;
    logic [31:0]      since_q;
    logic [POS_W-1:0] exp_pos;
    logic [POS_W-1:0] last_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            ok_q        <= 1'b0;
            sync_rate_q <= '0;
            since_q     <= '0;
        end else if (frame_i) begin
            ok_q        <= 1'b1;
            sync_rate_q <= rate_sel;
            since_q     <= 32'd1;
        end else begin
            if (rate_sel != sync_rate_q) ok_q <= 1'b0;
            since_q <= since_q + 32'd1;
        end
    end

    always_comb begin
        exp_pos = POS_W'(since_q & ((32'd1 << (chan_bits(rate_sel) + 3)) - 32'd1));
        last_c  = POS_W'((32'd1 << (chan_bits(rate_sel) + 3)) - 32'd1);
    end

    // R1: an unforced return to position 0 follows the last bit of the frame
    a_r1_frame_len: assert property (@(posedge clk) disable iff (rst)
        (!frame_i && pos == '0 && $stable(rate_sel) && !$past(rst)) |-> $past(pos) == last_c);

    // R2: position equals cycles since the last pulse, modulo the frame length
    a_r2_track: assert property (@(posedge clk) disable iff (rst)
        (ok_q && rate_sel == sync_rate_q && !frame_i) |-> pos == exp_pos);

    // R5 and R7: the drive enable never changes inside a channel
    a_r7_oe_hold: assert property (@(posedge clk) disable iff (rst)
        (pos[2:0] != 3'd0 && !$past(rst)) |-> $stable(ser_oe));

    // R8: first cycle out of reset drives nothing
    a_r8_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ser_oe == '0);
endmodule

bind tdm_tsi tdm_tsi_chk u_chk (
    .clk(clk), .rst(rst), .frame_i(frame_i), .rate_sel(rate_sel),
    .ser_oe(ser_oe), .pos(pos)
);

// File: tb/tdm_tsi_tb.sv
module tdm_tsi_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_i = 1'b0;
    logic [1:0] rate_sel = 2'b00;
    logic [7:0] ser_i = '0;
    logic [7:0] ser_o, ser_oe;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_stream = '0;
    logic [6:0] cfg_chan = '0;
    logic       cfg_oe = 1'b0, cfg_msg = 1'b0;
    logic [9:0] cfg_src = '0;
    logic [7:0] cfg_byte = '0;

    always #5 clk = ~clk;

    tdm_tsi u_dut (
        .clk(clk), .rst(rst), .frame_i(frame_i), .rate_sel(rate_sel),
        .ser_i(ser_i), .ser_o(ser_o), .ser_oe(ser_oe), .cfg_we(cfg_we),
        .cfg_stream(cfg_stream), .cfg_chan(cfg_chan), .cfg_oe(cfg_oe),
        .cfg_msg(cfg_msg), .cfg_src(cfg_src), .cfg_byte(cfg_byte)
    );

    typedef struct { bit oe; bit msg; int src; int mb; } ent_t;
    typedef struct { int o; int c; logic [7:0] b; bit oe; logic [15:0] tag; } exp_t;

    ent_t shd_m [8][128];
    ent_t act_m [8][128];
    exp_t exq [$];
    int   errors = 0, checks = 0, fnum = 0;
    bit   chk_frame = 0, done = 0;
    logic [15:0] ftag = "R0";

    // R1 model: channel-address width per rate code
    function automatic int cbits(input logic [1:0] r);
        if (r == 2'b01) return 6;
        if (r == 2'b10) return 7;
        return 5;
    endfunction

    function automatic logic [7:0] in_byte(input int f, input int s, input int c);
        return 8'((f * 29 + s * 71 + c * 3 + 7) ^ (c * 5));
    endfunction

    task automatic cfg_write(input int o, input int c, input bit oe, input bit msg,
                             input int src, input int mb);
        @(negedge clk);
        cfg_we = 1'b1; cfg_stream = 3'(o); cfg_chan = 7'(c);
        cfg_oe = oe; cfg_msg = msg; cfg_src = 10'(src); cfg_byte = 8'(mb);
        shd_m[o][c] = '{oe: oe, msg: msg, src: src, mb: mb};
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // driver: stages the model, pushes expectations, then drives one frame
    task automatic run_frame(input bit pulse, input bit check, input logic [15:0] tag,
                             input bit midw);
        int cb;
        int nch;
        cb  = cbits(rate_sel);
        nch = 1 << cb;
        fnum++;
        for (int o = 0; o < 8; o++)
            for (int c = 0; c < 128; c++) act_m[o][c] = shd_m[o][c];
        if (check) begin
            for (int c = 0; c < nch; c++) begin
                for (int o = 0; o < 8; o++) begin
                    exp_t e;
                    ent_t m;
                    m = act_m[o][c];
                    e.o = o; e.c = c;
                    if (!m.oe) begin
                        e.oe = 0; e.b = 8'h00; e.tag = "R5";
                    end else if (m.msg) begin
                        e.oe = 1; e.b = 8'(m.mb); e.tag = "R6";
                    end else begin
                        e.oe = 1; e.tag = "R4";
                        e.b = in_byte(fnum - 1, (m.src >> cb) & 7, m.src & (nch - 1));
                    end
                    exq.push_back(e);
                end
            end
        end
        for (int p = 0; p < nch * 8; p++) begin
            @(negedge clk);
            if (p == 0) begin chk_frame = check; ftag = tag; end
            frame_i = pulse && (p == 0);
            for (int s = 0; s < 8; s++) begin
                logic [7:0] v;
                v = in_byte(fnum, s, p / 8);
                ser_i[s] = v[7 - (p % 8)];
            end
            if (midw && p == 40) begin
                // R7: change a late channel mid-frame
                cfg_we = 1'b1; cfg_stream = 3'd0; cfg_chan = 7'd100;
                cfg_oe = 1'b1; cfg_msg = 1'b1; cfg_src = '0; cfg_byte = 8'h3C;
                shd_m[0][100] = '{oe: 1, msg: 1, src: 0, mb: 8'h3C};
            end
            if (midw && p == 41) cfg_we = 1'b0;
        end
    endtask

    // monitor: assembles each channel MSB first (R3) and compares against the queue
    int mpos = 0;
    logic [7:0] acc [8];
    logic [7:0] oeacc [8];
    always @(negedge clk) begin
        #2;
        if (frame_i) mpos = 0;
        else mpos = (mpos + 1) % (8 << cbits(rate_sel));
        if (chk_frame) begin
            for (int o = 0; o < 8; o++) begin
                acc[o][7 - (mpos % 8)]   = ser_o[o];
                oeacc[o][7 - (mpos % 8)] = ser_oe[o];
            end
            if (mpos % 8 == 7) begin
                for (int o = 0; o < 8; o++) begin
                    exp_t e;
                    checks++;
                    if (exq.size() == 0) begin
                        errors++;
                        $display("FAIL %s queue empty: o=%0d data %h expected none", ftag, o, acc[o]);
                    end else begin
                        e = exq.pop_front();
                        if (e.o != o || e.c != mpos / 8 || acc[o] !== e.b ||
                            oeacc[o] !== (e.oe ? 8'hFF : 8'h00)) begin
                            errors++;
                            $display("FAIL %s/%s o=%0d ch=%0d: data %h oe %h, expected data %h oe %h (o=%0d ch=%0d)",
                                     e.tag, ftag, o, mpos / 8, acc[o], oeacc[o], e.b,
                                     e.oe ? 8'hFF : 8'h00, e.o, e.c);
                        end
                    end
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            #2;
            checks++;
            if (ser_oe !== 8'h00 || ser_o !== 8'h00) begin
                errors++;
                $display("FAIL R8 reset state: oe %h data %h, expected oe 00 data 00", ser_oe, ser_o);
            end
        end
        @(negedge clk);

        // 32 channels per stream
        rate_sel = 2'b00;
        cfg_write(0, 0, 1, 0, (3 << 5) | 5, 0);
        cfg_write(1, 31, 1, 0, 31, 0);
        cfg_write(7, 10, 1, 0, (7 << 5), 0);
        cfg_write(2, 4, 1, 1, 0, 8'hA5);
        cfg_write(3, 6, 0, 0, (1 << 5) | 2, 0);
        run_frame(1, 0, "R1", 0);
        run_frame(1, 1, "R3", 0);
        run_frame(0, 1, "R2", 0);

        // 64 channels: same addresses split differently
        @(negedge clk);
        rate_sel = 2'b01;
        cfg_write(4, 63, 1, 0, (2 << 6) | 62, 0);
        cfg_write(5, 0, 1, 0, (6 << 6) | 40, 0);
        run_frame(1, 0, "R1", 0);
        run_frame(1, 1, "R1", 0);

        // 128 channels, with a write in the middle of a frame
        @(negedge clk);
        rate_sel = 2'b10;
        cfg_write(6, 127, 1, 0, (5 << 7) | 127, 0);
        run_frame(1, 0, "R1", 0);
        run_frame(1, 1, "R7", 1);
        run_frame(1, 1, "R7", 0);

        // unused rate code behaves as 32 channels
        @(negedge clk);
        rate_sel = 2'b11;
        run_frame(1, 0, "R1", 0);
        run_frame(1, 1, "R1", 0);
        run_frame(0, 1, "R1", 0);

        @(negedge clk);
        chk_frame = 0;
        @(negedge clk);
        checks++;
        if (exq.size() != 0) begin
            errors++;
            $display("FAIL R2 leftover expectations: %0d, expected 0", exq.size());
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule